// File: doc/BRIEF.md
# VFD Grid Multiplexer with Dimming

This block drives a multiplexed vacuum fluorescent display that has two or three grids sharing one set of 32 anode lines. A free-running scan divides time into one slot per grid. In each slot the matching grid is switched on, and the 32-bit segment word that belongs to that grid is placed on the shared segment bus. A 10-bit brightness value sets how much of each slot is lit. A strap pin chooses two-slot (duplex) or three-slot (triplex) scanning.

Time is counted in bit-times. One bit-time is a fixed number of clock enables on `tick`, four by default, and each slot is 1024 bit-times long. The segment bus and the dimming pulse open at the start of a slot. The grid turns on two bit-times later, stays on for the brightness count, and turns off one bit-time before the segments close. The brightness value, the three segment words and the strap are captured only when one frame ends and the next begins, so an update never changes a frame that is already in progress. Two sync outputs mark the lit window of the first and second slot, so that a slave driver can lock its frame to this block. All inputs are held levels and there is no data stream, so the block has no valid/ready handshake and no back-pressure. Inputs only need to be stable at a frame boundary.

Top module: `vfd_grid_mux`

## Requirements
- R1: While reset is asserted and until the first frame boundary after it, every `grid_n` bit is 1, `seg_out` is 0, and `dim_pulse`, `sync_g1` and `sync_g2` are 0.
- R2: The scan position advances by one bit-time every 4 asserted `tick` cycles and does not move while `tick` is 0. The outputs are registered and show the scan position of the previous clock cycle.
- R3: When `strap_duplex` is 1, a frame has 2 slots (2048 bit-times, 8192 ticks) and `grid_n[2]` stays 1. When it is 0, a frame has 3 slots (3072 bit-times, 12288 ticks), in the order grid 1, grid 2, grid 3.
- R4: A `dim_level` of 1016 or more gives the same on-time as 1016. The grid on-time is therefore never longer than 1016 of the 1024 bit-times in a slot.
- R5: The grids are active low. Only the grid of the current slot can be 0, and it is 0 for exactly E bit-times, starting 2 bit-times after the slot begins, where E is the clamped brightness value.
- R6: If E > 0, `dim_pulse` is 1 for the first E+3 bit-times of every slot. If E = 0, `dim_pulse` stays 0 and no grid turns on.
- R7: While `dim_pulse` is 1, `seg_out` equals the segment word of the current slot (`seg_g1` for slot 0, `seg_g2` for slot 1, `seg_g3` for slot 2), and bit n of `seg_out` is bit n of that word. At all other times `seg_out` is 0.
- R8: `sync_g1` equals `dim_pulse` during slot 0 and `sync_g2` equals `dim_pulse` during slot 1. Both are 0 in every other slot.
- R9: `dim_level`, `strap_duplex` and the three segment words are captured only at the clock edge that ends a frame. A change in the middle of a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oscillator clock enable; 4 ticks make one bit-time |
| strap_duplex | input | 1 | 1 selects two-grid scanning, 0 selects three-grid scanning |
| dim_level | input | 10 | Brightness, in bit-times of grid on-time per slot |
| seg_g1 | input | 32 | Segment word shown with grid 1 |
| seg_g2 | input | 32 | Segment word shown with grid 2 |
| seg_g3 | input | 32 | Segment word shown with grid 3 |
| grid_n | output | 3 | Grid enables, active low, bit 0 is grid 1 |
| seg_out | output | 32 | Shared segment bus, 1 lights the anode |
| dim_pulse | output | 1 | Lit-window pulse for a slave driver |
| sync_g1 | output | 1 | Lit window of the grid-1 slot |
| sync_g2 | output | 1 | Lit window of the grid-2 slot |

## Verification
The bench drives a brightness value above the clamp point and measures the grid-low run, the dimming pulse and the frame period against the values the requirements give. A design without the clamp would produce a grid run longer than 4064 clocks, and one with the wrong slot count would produce the wrong sync period. A zero brightness must leave the display dark; a design that still opens the three bit-times of segment lead would pulse `dim_pulse`. The bench also rewrites a segment word in the middle of a frame, where a design that does not hold its inputs per frame would show the new word at once. Finally it holds `tick` low and then gives only sparse ticks, so that any counter that advances without an enable pulls away from the bench's cycle-by-cycle reference.

// File: rtl/vfd_mux_pkg.sv
package vfd_mux_pkg;
  // Fixed structure of the scan: at most three grids share the segment bus.
  localparam int NUM_GRIDS = 3;
  localparam int SLOT_W    = 2;

  typedef logic [SLOT_W-1:0] slot_t;

  // Slot index of each grid in the scan order.
  localparam slot_t SLOT_G1 = 2'd0;
  localparam slot_t SLOT_G2 = 2'd1;
  localparam slot_t SLOT_G3 = 2'd2;

  // Index of the last slot of a frame, for the selected scan mode.
  function automatic slot_t last_slot(input logic two_slot);
    return two_slot ? SLOT_G2 : SLOT_G3;
  endfunction
endpackage

// File: rtl/vfd_mux_timebase.sv
module vfd_mux_timebase
  import vfd_mux_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int POS_W         = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             two_slot,
  output logic [POS_W-1:0] pos,
  output slot_t            slot,
  output logic             frame_wrap
);
  localparam int SUB_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);
  localparam logic [POS_W-1:0] POS_LAST = '1;

  logic [SUB_W-1:0] sub;
  logic             bit_end;
  logic             slot_end;
  slot_t            slot_top;

  assign bit_end    = tick && (sub == SUB_LAST);
  assign slot_end   = bit_end && (pos == POS_LAST);
  assign slot_top   = last_slot(two_slot);
  assign frame_wrap = slot_end && (slot >= slot_top);

  // Prescaler: ticks within one bit-time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
    end else if (tick) begin
      sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
    end
  end

  // Bit-time position inside the slot; wraps at the slot length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (bit_end) begin
      pos <= pos + 1'b1;
    end
  end

  // Slot index; two or three slots per frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= SLOT_G1;
    end else if (slot_end) begin
      slot <= frame_wrap ? SLOT_G1 : slot + 1'b1;
    end
  end
endmodule

// File: rtl/vfd_mux_shadow.sv
module vfd_mux_shadow
  import vfd_mux_pkg::*;
#(
  parameter int SEG_W  = 32,
  parameter int DIM_W  = 10,
  parameter int MAX_ON = 1016
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic                             strap_duplex,
  input  logic [DIM_W-1:0]                 dim_in,
  input  logic [NUM_GRIDS-1:0][SEG_W-1:0]  seg_in,
  output logic                             two_slot,
  output logic [DIM_W-1:0]                 eff_on,
  output logic [NUM_GRIDS-1:0][SEG_W-1:0]  seg_q
);
  localparam logic [DIM_W-1:0] MAX_ON_V = DIM_W'(MAX_ON);

  logic [DIM_W-1:0] dim_clamped;

  // Keep a blanking gap at the end of each slot.
  assign dim_clamped = (dim_in > MAX_ON_V) ? MAX_ON_V : dim_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      two_slot <= 1'b0;
      eff_on   <= '0;
    end else if (load) begin
      two_slot <= strap_duplex;
      eff_on   <= dim_clamped;
    end
  end

  // One frame-held copy per grid.
  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (load) begin
        seg_q[g] <= seg_in[g];
      end
    end
  end
endmodule

// File: rtl/vfd_mux_decode.sv
module vfd_mux_decode
  import vfd_mux_pkg::*;
#(
  parameter int SEG_W     = 32,
  parameter int DIM_W     = 10,
  parameter int SEG_LEAD  = 2,
  parameter int SEG_TRAIL = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DIM_W-1:0]                pos,
  input  slot_t                           slot,
  input  logic [DIM_W-1:0]                eff_on,
  input  logic [NUM_GRIDS-1:0][SEG_W-1:0] seg_q,
  output logic [NUM_GRIDS-1:0]            grid_n,
  output logic [SEG_W-1:0]                seg_out,
  output logic                            dim_pulse,
  output logic                            sync_g1,
  output logic                            sync_g2
);
  localparam int WIN_W = DIM_W + 2;

  logic [WIN_W-1:0] pos_x;
  logic [WIN_W-1:0] seg_end;
  logic [WIN_W-1:0] grid_beg;
  logic [WIN_W-1:0] grid_end;
  logic             lit;
  logic             seg_on;
  logic             grid_on;
  logic [SEG_W-1:0] seg_sel;

  assign pos_x    = WIN_W'(pos);
  assign seg_end  = WIN_W'(eff_on) + WIN_W'(SEG_LEAD + SEG_TRAIL);
  assign grid_beg = WIN_W'(SEG_LEAD);
  assign grid_end = WIN_W'(eff_on) + WIN_W'(SEG_LEAD);
  assign lit      = (eff_on != '0);
  assign seg_on   = lit && (pos_x < seg_end);
  assign grid_on  = lit && (pos_x >= grid_beg) && (pos_x < grid_end);

  // Pick the frame-held word of the slot being scanned.
  always_comb begin
    seg_sel = '0;
    for (int g = 0; g < NUM_GRIDS; g++) begin
      if (slot == SLOT_W'(g)) seg_sel = seg_q[g];
    end
  end

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_grid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grid_n[g] <= 1'b1;
      end else begin
        grid_n[g] <= !(grid_on && (slot == SLOT_W'(g)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_out   <= '0;
      dim_pulse <= 1'b0;
      sync_g1   <= 1'b0;
      sync_g2   <= 1'b0;
    end else begin
      seg_out   <= seg_on ? seg_sel : '0;
      dim_pulse <= seg_on;
      sync_g1   <= seg_on && (slot == SLOT_G1);
      sync_g2   <= seg_on && (slot == SLOT_G2);
    end
  end
endmodule

// File: rtl/vfd_grid_mux.sv
module vfd_grid_mux
  import vfd_mux_pkg::*;
#(
  parameter int SEG_W         = 32,
  parameter int DIM_W         = 10,
  parameter int TICKS_PER_BIT = 4,
  parameter int MAX_ON        = 1016,
  parameter int SEG_LEAD      = 2,
  parameter int SEG_TRAIL     = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 strap_duplex,
  input  logic [DIM_W-1:0]     dim_level,
  input  logic [SEG_W-1:0]     seg_g1,
  input  logic [SEG_W-1:0]     seg_g2,
  input  logic [SEG_W-1:0]     seg_g3,
  output logic [NUM_GRIDS-1:0] grid_n,
  output logic [SEG_W-1:0]     seg_out,
  output logic                 dim_pulse,
  output logic                 sync_g1,
  output logic                 sync_g2
);
  logic [NUM_GRIDS-1:0][SEG_W-1:0] seg_bundle;
  logic [NUM_GRIDS-1:0][SEG_W-1:0] seg_held;
  logic [DIM_W-1:0]                pos;
  slot_t                           slot;
  logic                            frame_wrap;
  logic                            two_slot;
  logic [DIM_W-1:0]                eff_on;

  assign seg_bundle = {seg_g3, seg_g2, seg_g1};

  vfd_mux_timebase #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .POS_W        (DIM_W)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .two_slot  (two_slot),
    .pos       (pos),
    .slot      (slot),
    .frame_wrap(frame_wrap)
  );

  vfd_mux_shadow #(
    .SEG_W (SEG_W),
    .DIM_W (DIM_W),
    .MAX_ON(MAX_ON)
  ) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (frame_wrap),
    .strap_duplex(strap_duplex),
    .dim_in      (dim_level),
    .seg_in      (seg_bundle),
    .two_slot    (two_slot),
    .eff_on      (eff_on),
    .seg_q       (seg_held)
  );

  vfd_mux_decode #(
    .SEG_W    (SEG_W),
    .DIM_W    (DIM_W),
    .SEG_LEAD (SEG_LEAD),
    .SEG_TRAIL(SEG_TRAIL)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos      (pos),
    .slot     (slot),
    .eff_on   (eff_on),
    .seg_q    (seg_held),
    .grid_n   (grid_n),
    .seg_out  (seg_out),
    .dim_pulse(dim_pulse),
    .sync_g1  (sync_g1),
    .sync_g2  (sync_g2)
  );
endmodule

// File: rtl/vfd_grid_mux_chk.sv
module vfd_grid_mux_chk #(
  parameter int SEG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             two_slot,
  input logic [2:0]       grid_n,
  input logic [SEG_W-1:0] seg_out,
  input logic             dim_pulse,
  input logic             sync_g1,
  input logic             sync_g2
);
  // R5: at most one grid is driven at a time
  a_r5_one_grid: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grid_n));

  // R3: two-slot scanning never drives the third grid
  a_r3_duplex_no_g3: assert property (@(posedge clk) disable iff (!rst_n)
    two_slot |-> grid_n[2]);

  // R6: a driven grid sits inside the lit window
  a_r6_grid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_n != 3'b111) |-> dim_pulse);

  // R7: the segment bus is blank outside the lit window
  a_r7_seg_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_pulse |-> (seg_out == '0));

  // R8: sync pulses are exclusive and inside the lit window
  a_r8_sync_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_g1 && sync_g2));

  a_r8_sync_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_g1 || sync_g2) |-> dim_pulse);

  // R2: without a tick the scan stands still
  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> ##2 ($stable(grid_n) && $stable(seg_out) && $stable(dim_pulse)
                   && $stable(sync_g1) && $stable(sync_g2)));
endmodule

bind vfd_grid_mux vfd_grid_mux_chk #(.SEG_W(SEG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .two_slot (two_slot),
  .grid_n   (grid_n),
  .seg_out  (seg_out),
  .dim_pulse(dim_pulse),
  .sync_g1  (sync_g1),
  .sync_g2  (sync_g2)
);

// File: tb/vfd_grid_mux_bench.sv
module vfd_grid_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        strap_duplex = 1'b0;
  logic [9:0]  dim_level = '0;
  logic [31:0] seg_g1 = '0;
  logic [31:0] seg_g2 = '0;
  logic [31:0] seg_g3 = '0;
  logic [2:0]  grid_n;
  logic [31:0] seg_out;
  logic        dim_pulse;
  logic        sync_g1;
  logic        sync_g2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vfd_grid_mux u_vfd_grid_mux (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strap_duplex(strap_duplex),
    .dim_level(dim_level), .seg_g1(seg_g1), .seg_g2(seg_g2), .seg_g3(seg_g3),
    .grid_n(grid_n), .seg_out(seg_out), .dim_pulse(dim_pulse),
    .sync_g1(sync_g1), .sync_g2(sync_g2)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model (scoreboard producer) ----------------
  typedef struct packed {
    logic [2:0]  g;
    logic [31:0] s;
    logic        d;
    logic        y1;
    logic        y2;
  } exp_t;

  exp_t exp_q[$];
  int   m_sub, m_pos, m_slot, m_eff;
  bit   m_dup;
  logic [31:0] m_seg [3];

  function automatic exp_t predict();
    exp_t e;
    bit   son, gon;
    son = (m_eff != 0) && (m_pos < m_eff + 3);
    gon = (m_eff != 0) && (m_pos >= 2) && (m_pos < m_eff + 2);
    e.s  = son ? m_seg[m_slot] : 32'h0;
    e.d  = son;
    e.y1 = son && (m_slot == 0);
    e.y2 = son && (m_slot == 1);
    for (int g = 0; g < 3; g++) e.g[g] = !(gon && (m_slot == g));
    return e;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_sub = 0; m_pos = 0; m_slot = 0; m_eff = 0; m_dup = 0;
      for (int g = 0; g < 3; g++) m_seg[g] = '0;
      e = '{g: 3'b111, s: 32'h0, d: 1'b0, y1: 1'b0, y2: 1'b0};
    end else begin
      e = predict();
      if (tick) begin
        if (m_sub == 3) begin
          m_sub = 0;
          if (m_pos == 1023) begin
            m_pos = 0;
            if (m_slot == (m_dup ? 1 : 2)) begin
              m_slot = 0;
              m_dup  = strap_duplex;
              m_eff  = (dim_level > 10'd1015) ? 1016 : int'(dim_level);
              m_seg[0] = seg_g1; m_seg[1] = seg_g2; m_seg[2] = seg_g3;
            end else begin
              m_slot = m_slot + 1;
            end
          end else begin
            m_pos = m_pos + 1;
          end
        end else begin
          m_sub = m_sub + 1;
        end
      end
    end
    exp_q.push_back(e);
  end

  // ---------------- monitor (scoreboard consumer) ----------------
  always @(negedge clk) begin
    exp_t e;
    if (!done && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      if (grid_n !== e.g)
        chk(1'b0, "R5", "grid_n vs model", grid_n, e.g);
      else if (dim_pulse !== e.d)
        chk(1'b0, "R6", "dim_pulse vs model", dim_pulse, e.d);
      else if (seg_out !== e.s)
        chk(1'b0, "R7", "seg_out vs model", seg_out, e.s);
      else if ({sync_g1, sync_g2} !== {e.y1, e.y2})
        chk(1'b0, "R8", "sync vs model", {sync_g1, sync_g2}, {e.y1, e.y2});
      else
        chk(1'b1, "R2", "model", 0, 0);
    end
  end

  // ---------------- measurement helpers ----------------
  function automatic logic pick(input int w);
    case (w)
      0:       return dim_pulse;
      1:       return ~&grid_n;
      default: return sync_g1;
    endcase
  endfunction

  task automatic wait_rise(input int w);
    do @(negedge clk); while (pick(w) !== 1'b0);
    do @(negedge clk); while (pick(w) !== 1'b1);
  endtask

  task automatic high_len(input int w, output int n);
    wait_rise(w);
    n = 0;
    while (pick(w) === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic period(input int w, output int n);
    wait_rise(w);
    n = 0;
    while (pick(w) === 1'b1) begin n++; @(negedge clk); end
    while (pick(w) !== 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic settle();
    repeat (13000) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    bit ok;
    logic [2:0]  hg;
    logic [31:0] hs;
    logic        hd;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk(grid_n === 3'b111, "R1", "grid_n in reset", grid_n, 3'b111);
    chk(seg_out === 32'h0 && dim_pulse === 1'b0 && sync_g1 === 1'b0 && sync_g2 === 1'b0,
        "R1", "segments and pulses in reset", {seg_out, dim_pulse}, 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(grid_n === 3'b111 && dim_pulse === 1'b0, "R1", "dark before first boundary",
        {grid_n, dim_pulse}, 4'b1110);

    // Triplex, level above the clamp point (R4, R3)
    strap_duplex = 1'b0; dim_level = 10'd1023;
    seg_g1 = 32'h8000_0001; seg_g2 = 32'h0F0F_F0F0; seg_g3 = 32'hA5A5_5A5A;
    settle();
    high_len(1, n);
    chk(n == 4064, "R4", "clamped grid-low run (clocks)", n, 4064);
    high_len(0, n);
    chk(n == 4076, "R6", "lit window at clamp (clocks)", n, 4076);
    period(2, n);
    chk(n == 12288, "R3", "triplex frame period", n, 12288);

    // Duplex, level 64 (R5, R6, R3)
    strap_duplex = 1'b1; dim_level = 10'd64;
    settle();
    high_len(1, n);
    chk(n == 256, "R5", "grid-low run at 64", n, 256);
    high_len(0, n);
    chk(n == 268, "R6", "lit window at 64", n, 268);
    period(2, n);
    chk(n == 8192, "R3", "duplex frame period", n, 8192);
    ok = 1'b1;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (grid_n[2] !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R3", "grid 3 idle in duplex", ok, 1);

    // Level zero: dark display (R6)
    dim_level = 10'd0;
    settle();
    ok = 1'b1;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (dim_pulse !== 1'b0 || grid_n !== 3'b111 || seg_out !== 32'h0) ok = 1'b0;
    end
    chk(ok, "R6", "no activity at level 0", ok, 1);

    // Mid-frame update held off (R9, R7)
    dim_level = 10'd500; seg_g1 = 32'h1234_5678;
    repeat (9000) @(negedge clk);
    wait_rise(2);
    repeat (100) @(negedge clk);
    seg_g1 = 32'hCAFE_0001; dim_level = 10'd20;
    repeat (20) @(negedge clk);
    chk(seg_out === 32'h1234_5678, "R9", "old word kept in frame", seg_out, 32'h1234_5678);
    chk(dim_pulse === 1'b1, "R9", "old level kept in frame", dim_pulse, 1);
    wait_rise(2);
    repeat (10) @(negedge clk);
    chk(seg_out === 32'hCAFE_0001, "R7", "new grid-1 word next frame", seg_out, 32'hCAFE_0001);

    // Tick gating (R2)
    dim_level = 10'd300;
    repeat (9000) @(negedge clk);
    wait_rise(0);
    repeat (5) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    hg = grid_n; hs = seg_out; hd = dim_pulse;
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (grid_n !== hg || seg_out !== hs || dim_pulse !== hd) ok = 1'b0;
    end
    chk(ok, "R2", "outputs frozen without tick", ok, 1);
    for (int i = 0; i < 3000; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b1;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule